// File: doc/BRIEF.md
# Microsecond Timestamp Timer with One-Shot Compare

This block keeps a free-running 64-bit timestamp that advances once per microsecond. A prescaler divides the core clock down to that rate. The count begins at reset and never halts. Software reads it through a small 32-bit register port. Reading the low word captures the upper half in a shadow register, so that a following read of the high word yields a coherent 64-bit value even when a carry crosses the word boundary between the two accesses.

A single compare channel provides one-shot event timing. Software disables the compare, loads the upper compare half and then the lower half, and enables it again. Loading the lower half commits all 64 bits at once. While the compare is armed, the block raises a sticky hit flag once the timestamp reaches or passes the committed value. The level interrupt is that flag gated by the enable. Writing a one to the status bit clears the flag. Drivers normally keep at least 100 ticks between the current time and the programmed value.

Top module: `usec_stamp_timer`

## Requirements
- R1: After a synchronous reset, the control and status words read 0, both compare words read 0, `irq_o` is low and the timestamp begins at `START_VALUE`.
- R2: The timestamp increases by exactly one for every `CORE_DIV` core clock cycles, with no software set-up.
- R3: A read of offset 0x00 returns timestamp bits 31:0 and latches bits 63:32 into a shadow. A read of offset 0x04 returns that shadow, so a low-then-high pair stays coherent across a carry.
- R4: A write to offset 0x0C only stages the upper compare half. A write to offset 0x08 commits {staged upper, written lower} as the 64-bit compare value. Offsets 0x08 and 0x0C read back the committed value.
- R5: A write to control offset 0x10 changes the compare enable (bit 0) only when bit 1 of the written data is 1. Control reads return the enable in bit 0.
- R6: While the enable is 1 and timestamp >= compare, the hit flag (status offset 0x14, bit 0) sets. `irq_o` goes high on the clock after the flag and enable are both 1.
- R7: With the enable at 0, `irq_o` is low and no new hit is recorded. A flag that is already set stays set.
- R8: Writing status bit 0 as 1 clears the flag. Writing it as 0 leaves the flag unchanged.
- R9: When a hit and a clearing write fall on the same cycle, the flag stays set.
- R10: The timestamp wraps from all ones to zero.
- R11: Read data appears on `rdata_o` on the clock after `rd_en_i`. Unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_i | input | ADDR_W | Byte offset of the register access |
| wr_en_i | input | 1 | Write strobe for one cycle |
| rd_en_i | input | 1 | Read strobe for one cycle |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Registered read data |
| irq_o | output | 1 | Level compare-match interrupt |

## Verification
The bench polls the low word until the count is a few ticks short of a 32-bit carry. It then waits well past the carry before reading the high word. A design that reads the live upper half would return one too many there. Compare staging is checked by reading back after an upper-only write: a design that commits early would show the new upper half. Writes to the control word without the qualifier must leave the enable untouched, and a premature or missing hit shows up in status reads taken before and after the programmed time. A clearing write while the match still holds must not drop the flag, a write of zero must not clear it, and a second instance started near all ones must read a small value after it wraps.

// File: rtl/usec_timer_pkg.sv
package usec_timer_pkg;
  localparam logic [7:0] OFS_STAMP_LO = 8'h00;
  localparam logic [7:0] OFS_STAMP_HI = 8'h04;
  localparam logic [7:0] OFS_CMP_LO   = 8'h08;
  localparam logic [7:0] OFS_CMP_HI   = 8'h0C;
  localparam logic [7:0] OFS_CTRL     = 8'h10;
  localparam logic [7:0] OFS_STATUS   = 8'h14;
  localparam int CTRL_EN_BIT   = 0;
  localparam int CTRL_QUAL_BIT = 1;
  localparam int STATUS_HIT_BIT = 0;
endpackage

// File: rtl/tick_prescaler.sv
module tick_prescaler #(
  parameter int DIV = 50
) (
  input  logic clk,
  input  logic rst,
  output logic tick_o
);
  generate
    if (DIV <= 1) begin : g_pass
      always_ff @(posedge clk) tick_o <= !rst;
    end else begin : g_div
      localparam int CW = $clog2(DIV);
      logic [CW-1:0] phase_q;
      always_ff @(posedge clk) begin
        if (rst) begin
          phase_q <= '0;
          tick_o  <= 1'b0;
        end else if (phase_q == CW'(DIV - 1)) begin
          phase_q <= '0;
          tick_o  <= 1'b1;
        end else begin
          phase_q <= phase_q + CW'(1);
          tick_o  <= 1'b0;
        end
      end
      // R2: ticks are never back to back when dividing
      assert_tick_spacing_R2: assert property (@(posedge clk) disable iff (rst)
        tick_o |=> !tick_o);
    end
  endgenerate
endmodule

// File: rtl/stamp_counter.sv
module stamp_counter #(
  parameter int W = 64,
  parameter logic [W-1:0] START = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick_i,
  output logic [W-1:0] stamp_o
);
  always_ff @(posedge clk) begin
    if (rst)         stamp_o <= START;
    else if (tick_i) stamp_o <= stamp_o + W'(1);
  end

  // R2 / R10: one step per tick, modulo 2^W
  assert_step_R2: assert property (@(posedge clk) disable iff (rst)
    tick_i |=> stamp_o == $past(stamp_o) + W'(1));
  assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !tick_i |=> $stable(stamp_o));
endmodule

// File: rtl/compare_ctrl.sv
module compare_ctrl #(
  parameter int W  = 64,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [W-1:0]  stamp_i,
  input  logic          hi_wr_i,
  input  logic          lo_wr_i,
  input  logic          ctl_wr_i,
  input  logic          sts_wr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [W-1:0]  cmp_o,
  output logic          en_o,
  output logic          hit_o,
  output logic          irq_o
);
  import usec_timer_pkg::*;
  localparam int HW = W - DW;

  logic [HW-1:0] stage_q;
  logic          match;
  logic          clr_req;

  assign match   = en_o && (stamp_i >= cmp_o);
  assign clr_req = sts_wr_i && wdata_i[STATUS_HIT_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      stage_q <= '0;
      cmp_o   <= '0;
    end else begin
      if (hi_wr_i) stage_q <= wdata_i[HW-1:0];
      if (lo_wr_i) cmp_o   <= {stage_q, wdata_i};
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                                    en_o <= 1'b0;
    else if (ctl_wr_i && wdata_i[CTRL_QUAL_BIT]) en_o <= wdata_i[CTRL_EN_BIT];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hit_o <= 1'b0;
      irq_o <= 1'b0;
    end else begin
      if (match)        hit_o <= 1'b1;
      else if (clr_req) hit_o <= 1'b0;
      irq_o <= hit_o && en_o;
    end
  end

  assert_commit_only_low_R4: assert property (@(posedge clk) disable iff (rst)
    (hi_wr_i && !lo_wr_i) |=> $stable(cmp_o));
  assert_ctrl_unqualified_R5: assert property (@(posedge clk) disable iff (rst)
    (ctl_wr_i && !wdata_i[CTRL_QUAL_BIT]) |=> $stable(en_o));
  assert_ctrl_qualified_R5: assert property (@(posedge clk) disable iff (rst)
    (ctl_wr_i && wdata_i[CTRL_QUAL_BIT]) |=> en_o == $past(wdata_i[CTRL_EN_BIT]));
  assert_irq_gated_R7: assert property (@(posedge clk) disable iff (rst)
    !en_o |=> !irq_o);
  assert_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    (hit_o && !clr_req) |=> hit_o);
  assert_set_wins_R9: assert property (@(posedge clk) disable iff (rst)
    match |=> hit_o);
endmodule

// File: rtl/usec_stamp_timer.sv
module usec_stamp_timer #(
  parameter int CORE_DIV = 50,
  parameter int STAMP_W  = 64,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 8,
  parameter logic [STAMP_W-1:0] START_VALUE = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  import usec_timer_pkg::*;
  localparam int HI_W = STAMP_W - DATA_W;

  logic               tick;
  logic [STAMP_W-1:0] stamp;
  logic [STAMP_W-1:0] cmp;
  logic               en;
  logic               hit;
  logic [HI_W-1:0]    shadow_q;
  logic               sel_hi, sel_lo, sel_ctl, sel_sts;

  tick_prescaler #(.DIV(CORE_DIV)) u_presc (
    .clk(clk), .rst(rst), .tick_o(tick));

  stamp_counter #(.W(STAMP_W), .START(START_VALUE)) u_count (
    .clk(clk), .rst(rst), .tick_i(tick), .stamp_o(stamp));

  assign sel_hi  = wr_en_i && (addr_i == ADDR_W'(OFS_CMP_HI));
  assign sel_lo  = wr_en_i && (addr_i == ADDR_W'(OFS_CMP_LO));
  assign sel_ctl = wr_en_i && (addr_i == ADDR_W'(OFS_CTRL));
  assign sel_sts = wr_en_i && (addr_i == ADDR_W'(OFS_STATUS));

  compare_ctrl #(.W(STAMP_W), .DW(DATA_W)) u_cmp (
    .clk(clk), .rst(rst), .stamp_i(stamp),
    .hi_wr_i(sel_hi), .lo_wr_i(sel_lo), .ctl_wr_i(sel_ctl), .sts_wr_i(sel_sts),
    .wdata_i(wdata_i), .cmp_o(cmp), .en_o(en), .hit_o(hit), .irq_o(irq_o));

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_o  <= '0;
      shadow_q <= '0;
    end else if (rd_en_i) begin
      case (addr_i)
        ADDR_W'(OFS_STAMP_LO): begin
          rdata_o  <= stamp[DATA_W-1:0];
          shadow_q <= stamp[STAMP_W-1:DATA_W];
        end
        ADDR_W'(OFS_STAMP_HI): rdata_o <= DATA_W'(shadow_q);
        ADDR_W'(OFS_CMP_LO):   rdata_o <= cmp[DATA_W-1:0];
        ADDR_W'(OFS_CMP_HI):   rdata_o <= DATA_W'(cmp[STAMP_W-1:DATA_W]);
        ADDR_W'(OFS_CTRL):     rdata_o <= DATA_W'(en);
        ADDR_W'(OFS_STATUS):   rdata_o <= DATA_W'(hit);
        default:               rdata_o <= '0;
      endcase
    end
  end

  // R3: the shadow only moves on a low-word read
  assert_shadow_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !(rd_en_i && addr_i == ADDR_W'(OFS_STAMP_LO)) |=> $stable(shadow_q));
  // R11: read data holds between reads
  assert_rdata_hold_R11: assert property (@(posedge clk) disable iff (rst)
    !rd_en_i |=> $stable(rdata_o));
endmodule

// File: tb/sim_usec_stamp_timer.sv
module sim_usec_stamp_timer;
  localparam int CLK_PERIOD = 10;
  localparam int DIV = 4;
  localparam logic [63:0] START0 = 64'h0000_0001_FFFF_FFF0;
  localparam logic [63:0] START1 = 64'hFFFF_FFFF_FFFF_FFFC;
  localparam logic [7:0] A_SLO = 8'h00, A_SHI = 8'h04, A_CLO = 8'h08,
                         A_CHI = 8'h0C, A_CTL = 8'h10, A_STS = 8'h14;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [7:0] addr = '0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata0, rdata1;
  logic irq0, irq1;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  bit          q_chk[$];
  logic [31:0] q_exp[$];
  string       q_tag[$];
  logic        rd_seen = 1'b0;
  logic [31:0] cap0, cap1;

  always #(CLK_PERIOD/2) clk = ~clk;

  usec_stamp_timer #(.CORE_DIV(DIV), .START_VALUE(START0)) u0 (
    .clk(clk), .rst(rst), .addr_i(addr), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .wdata_i(wdata), .rdata_o(rdata0), .irq_o(irq0));
  usec_stamp_timer #(.CORE_DIV(DIV), .START_VALUE(START1)) u1 (
    .clk(clk), .rst(rst), .addr_i(addr), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .wdata_i(wdata), .rdata_o(rdata1), .irq_o(irq1));

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops expectations as read data appears
  always @(posedge clk) rd_seen <= rd_en;
  always @(negedge clk) begin
    if (rd_seen) begin
      if (q_chk.size() == 0) begin
        check(1'b0, "scoreboard empty", 64'(rdata0), 64'h0);
      end else begin
        bit c; logic [31:0] e; string t;
        c = q_chk.pop_front(); e = q_exp.pop_front(); t = q_tag.pop_front();
        if (c) check(rdata0 === e, t, 64'(rdata0), 64'(e));
        cap0 = rdata0;
        cap1 = rdata1;
      end
    end
  end

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [7:0] a, input logic [31:0] e, input string t);
    q_chk.push_back(1'b1); q_exp.push_back(e); q_tag.push_back(t);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic bus_cap(input logic [7:0] a, output logic [31:0] d0,
                         output logic [31:0] d1);
    q_chk.push_back(1'b0); q_exp.push_back('0); q_tag.push_back("cap");
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    #1;
    d0 = cap0; d1 = cap1;
  endtask

  task automatic read_stamp(output logic [63:0] v0, output logic [63:0] v1);
    logic [31:0] l0, l1, h0, h1;
    bus_cap(A_SLO, l0, l1);
    bus_cap(A_SHI, h0, h1);
    v0 = {h0, l0}; v1 = {h1, l1};
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic report;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      report();
      $finish;
    end
  end

  initial begin
    logic [63:0] v, w, v1, w1;
    logic [31:0] l0, l1;
    idle(5);
    rst = 1'b0;

    // R1 reset state, R11 unmapped read
    check(irq0 === 1'b0, "R1 irq low after reset", 64'(irq0), 64'h0);
    bus_rd(A_CTL, 32'h0, "R1 control reset");
    bus_rd(A_STS, 32'h0, "R1 status reset");
    bus_rd(A_CLO, 32'h0, "R1 compare low reset");
    bus_rd(A_CHI, 32'h0, "R1 compare high reset");
    bus_rd(8'h18, 32'h0, "R11 unmapped offset");
    read_stamp(v, v1);
    check(v >= START0 && v < START0 + 64'd8, "R1 timestamp start", v, START0);

    // R3: low read just before the carry, high read long after it
    bus_cap(A_SLO, l0, l1);
    while (l0 < 32'hFFFF_FFF8 && l0 >= 32'hFFFF_FFF0) bus_cap(A_SLO, l0, l1);
    check(l0 >= 32'hFFFF_FFF8, "R3 reached pre-carry window", 64'(l0), 64'hFFFF_FFF8);
    idle(40);
    bus_rd(A_SHI, 32'h1, "R3 shadow high across carry");
    read_stamp(v, v1);
    check(v[63:32] == 32'h2, "R3 high word after carry", v, 64'h2_0000_0000);
    // R10: second instance wrapped through all ones
    check(v1 < 64'd64, "R10 wrap to zero", v1, 64'h0);

    // R2: exactly one step per DIV clocks (lo reads 40 cycles apart)
    read_stamp(v, v1);
    idle(38);
    read_stamp(w, w1);
    check(w - v == 64'd10, "R2 tick rate", w - v, 64'd10);

    // R4: staging and commit of the compare value
    bus_wr(A_CTL, 32'h2);
    bus_wr(A_CHI, 32'h1234);
    bus_rd(A_CHI, 32'h0, "R4 high staged not committed");
    bus_rd(A_CLO, 32'h0, "R4 low unchanged");
    bus_wr(A_CLO, 32'h5678);
    bus_rd(A_CHI, 32'h1234, "R4 high committed");
    bus_rd(A_CLO, 32'h5678, "R4 low committed");

    // R5: qualifier bit
    bus_wr(A_CTL, 32'h1);
    bus_rd(A_CTL, 32'h0, "R5 unqualified enable ignored");
    bus_wr(A_CTL, 32'h3);
    bus_rd(A_CTL, 32'h1, "R5 qualified enable");
    bus_rd(A_STS, 32'h0, "R6 no hit for future compare");
    bus_wr(A_CTL, 32'h0);
    bus_rd(A_CTL, 32'h1, "R5 unqualified disable ignored");
    bus_wr(A_CTL, 32'h2);
    bus_rd(A_CTL, 32'h0, "R5 qualified disable");

    // R6: one-shot match
    read_stamp(v, v1);
    w = v + 64'd40;
    bus_wr(A_CHI, w[63:32]);
    bus_wr(A_CLO, w[31:0]);
    bus_wr(A_CTL, 32'h3);
    bus_rd(A_STS, 32'h0, "R6 no hit before compare time");
    check(irq0 === 1'b0, "R6 irq low before compare time", 64'(irq0), 64'h0);
    idle(200);
    bus_rd(A_STS, 32'h1, "R6 hit after compare time");
    check(irq0 === 1'b1, "R6 irq high on hit", 64'(irq0), 64'h1);

    // R9: clear while match persists
    bus_wr(A_STS, 32'h1);
    bus_rd(A_STS, 32'h1, "R9 set beats clear");
    check(irq0 === 1'b1, "R9 irq stays high", 64'(irq0), 64'h1);
    // R8: writing zero does nothing
    bus_wr(A_STS, 32'h0);
    bus_rd(A_STS, 32'h1, "R8 zero write keeps flag");

    // R7: disable gates irq, flag retained
    bus_wr(A_CTL, 32'h2);
    idle(2);
    check(irq0 === 1'b0, "R7 irq low when disabled", 64'(irq0), 64'h0);
    bus_rd(A_STS, 32'h1, "R7 flag retained when disabled");
    bus_wr(A_STS, 32'h1);
    bus_rd(A_STS, 32'h0, "R8 one write clears flag");
    idle(20);
    bus_rd(A_STS, 32'h0, "R7 no new hit while disabled");
    check(irq0 === 1'b0, "R7 irq stays low", 64'(irq0), 64'h0);

    // R6: re-arm with compare already passed
    bus_wr(A_CTL, 32'h3);
    idle(3);
    check(irq0 === 1'b1, "R6 irq on re-arm past compare", 64'(irq0), 64'h1);

    idle(4);
    check(q_chk.size() == 0, "scoreboard drained", 64'(q_chk.size()), 64'h0);
    done = 1;
    report();
    $finish;
  end
endmodule